// File: doc/BRIEF.md
# Station Address Table Loader and Destination Filter

This block keeps a table of sixteen 48-bit station addresses, each gated by one bit of a 16-bit enable mask. Software points the block at a list of address descriptors in memory, gives a 5-bit entry count and issues a load command. A small sequencer then walks the list over a word-read memory port, fills consecutive table entries, and finally fetches the enable mask from the descriptor that follows the last entry. A descriptor can be laid out in 16-bit or 32-bit data mode.

For every frame destination presented to it, the block returns a registered accept/reject decision and a tag. The tag marks a frame accepted as broadcast or as multicast. The decision is taken in a fixed order: promiscuous unicast first, then all-multicast, then broadcast, then the enabled table entries. While the controller is in reset mode, software can read back any entry as three 16-bit byte pairs.

Top module: `addr_cam_filter`

## Requirements
- R1: A `load_cmd` pulse while idle latches `cnt_init`, `ptr_init` and `wide_mode`, raises `load_busy` on the next edge and clears `load_done`. A `load_cmd` that arrives while `load_busy` is high has no effect on the pointer, the count or the table.
- R2: For each entry the sequencer reads words 1, 2 and 3 of the descriptor and never reads word 0. Entry byte 2k is the low byte of word k+1 and byte 2k+1 is its high byte. Entry number n of a load is written to table slot n modulo 16.
- R3: The loop runs while `cnt_q` is nonzero. Each entry written decrements `cnt_q` by one and advances `ptr_q` by one descriptor: 8 bytes in 16-bit mode, 16 bytes in 32-bit mode. Between entry writes the count does not change.
- R4: After the last entry, or at once when the count starts at zero, word 0 of the descriptor at `ptr_q` is read and becomes the enable mask. Bit i of the mask enables slot i. `ptr_q` is not advanced past this descriptor.
- R5: In the cycle the mask word is taken, `load_busy` falls and `load_done` rises. `load_done` stays high until the next accepted load command.
- R6: In 32-bit mode (`wide_mode`=1) descriptor word k sits at byte address `ptr_q`+4k. In 16-bit mode it sits at `ptr_q`+2k.
- R7: With `promisc_en` set, a destination whose bit 0 (the group bit of the first byte) is clear is accepted with tag 0. A group destination falls through to the later checks.
- R8: With `allmc_en` set, a destination with the group bit set is accepted with tag 16'h0100. This takes priority over broadcast.
- R9: With `bcast_en` set, the all-ones destination is accepted with tag 16'h0080, unless R7 or R8 has already decided.
- R10: Otherwise the frame is accepted with tag 0 if it equals an enabled table entry, and rejected with tag 0 if it does not. `res_valid`, `res_accept` and `res_tag` appear one clock after `frame_valid` is sampled. `dst_addr` byte k is bits [8k+7:8k], and byte 0 is the first byte received.
- R11: With `rd_reset_mode` high, `rd_cap0`, `rd_cap1` and `rd_cap2` return bytes {1,0}, {3,2} and {5,4} of slot `rd_sel`. With it low, all three read zero.
- R12: A lookup sampled on the same edge as a table or mask write uses the contents held before that edge.
- R13: `mem_req` is held, with `mem_addr` stable, until `mem_ack` is seen. `mem_rdata` is taken in the cycle `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_cmd | input | 1 | Load-table command pulse |
| wide_mode | input | 1 | 1 = 32-bit descriptor layout |
| cnt_init | input | 5 | Number of entries to load |
| ptr_init | input | AW | Byte address of the first descriptor |
| load_busy | output | 1 | Load command pending |
| load_done | output | 1 | Load-complete status |
| cnt_q | output | 5 | Remaining entry count |
| ptr_q | output | AW | Current descriptor pointer |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |
| promisc_en | input | 1 | Accept all unicast |
| allmc_en | input | 1 | Accept all group addresses |
| bcast_en | input | 1 | Accept broadcast |
| frame_valid | input | 1 | Destination present this cycle |
| dst_addr | input | 48 | Frame destination address |
| res_valid | output | 1 | Decision valid |
| res_accept | output | 1 | Frame accepted |
| res_tag | output | 16 | 16'h0100 multicast, 16'h0080 broadcast, else 0 |
| rd_reset_mode | input | 1 | Controller in reset mode; enables read-back |
| rd_sel | input | 4 | Slot to read back |
| rd_cap0 | output | 16 | Bytes 1:0 of the selected slot |
| rd_cap1 | output | 16 | Bytes 3:2 of the selected slot |
| rd_cap2 | output | 16 | Bytes 5:4 of the selected slot |

## Verification
The loader's final mask write and a destination lookup can occur on the same clock edge. The bench provokes this by starting a zero-count load, which reads only the mask. Because the bench's own memory model acknowledges with a known one-cycle wait, the bench can present a frame exactly on the edge where the new mask is committed. That frame must be judged against the old mask, so it is rejected. The same destination presented one cycle later must be accepted under the new mask.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_ENTRY = 2'd1,
    LD_MASK  = 2'd2
  } ld_state_e;

  localparam logic [15:0] TAG_MCAST = 16'h0100;
  localparam logic [15:0] TAG_BCAST = 16'h0080;

  typedef struct packed {
    logic        accept;
    logic [15:0] tag;
  } verdict_t;

  // byte offset of descriptor word w inside a descriptor
  function automatic logic [4:0] desc_word_off(input logic [1:0] w, input logic wide);
    return {2'b00, w, 1'b0} << wide;
  endfunction

  // byte distance between consecutive descriptors
  function automatic logic [4:0] desc_step(input logic wide);
    return 5'd8 << wide;
  endfunction

  // ordered acceptance decision
  function automatic verdict_t classify(input logic pro, input logic amc, input logic brd,
                                        input logic [47:0] dst, input logic hit);
    verdict_t v;
    v.accept = 1'b0;
    v.tag    = '0;
    if (pro && !dst[0]) begin
      v.accept = 1'b1;
    end else if (amc && dst[0]) begin
      v.accept = 1'b1;
      v.tag    = TAG_MCAST;
    end else if (brd && (&dst)) begin
      v.accept = 1'b1;
      v.tag    = TAG_BCAST;
    end else if (hit) begin
      v.accept = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/cam_load_seq.sv
module cam_load_seq
  import cam_pkg::*;
#(
  parameter int AW    = 32,
  parameter int N_ENT = 16,
  parameter int CW    = 5,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_cmd,
  input  logic          wide_mode,
  input  logic [CW-1:0] cnt_init,
  input  logic [AW-1:0] ptr_init,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] cnt_q,
  output logic [AW-1:0] ptr_q,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          ent_we,
  output logic [IW-1:0] ent_idx,
  output logic [47:0]   ent_data,
  output logic          mask_we,
  output logic [15:0]   mask_data
);

  ld_state_e   state;
  logic [1:0]  wsel;
  logic [15:0] stage_lo;
  logic [15:0] stage_mid;
  logic        wide_q;
  logic [1:0]  cur_word;

  assign busy      = (state != LD_IDLE);
  assign mem_req   = busy;
  assign cur_word  = (state == LD_MASK) ? 2'd0 : wsel;
  assign mem_addr  = ptr_q + AW'(desc_word_off(cur_word, wide_q));
  assign ent_we    = (state == LD_ENTRY) && mem_ack && (wsel == 2'd3);
  assign ent_data  = {mem_rdata, stage_mid, stage_lo};
  assign mask_we   = (state == LD_MASK) && mem_ack;
  assign mask_data = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LD_IDLE;
      wsel      <= 2'd1;
      stage_lo  <= '0;
      stage_mid <= '0;
      wide_q    <= 1'b0;
      cnt_q     <= '0;
      ptr_q     <= '0;
      ent_idx   <= '0;
      done      <= 1'b0;
    end else begin
      unique case (state)
        LD_IDLE: begin
          if (load_cmd) begin
            cnt_q   <= cnt_init;
            ptr_q   <= ptr_init;
            wide_q  <= wide_mode;
            ent_idx <= '0;
            wsel    <= 2'd1;
            done    <= 1'b0;
            state   <= (cnt_init != '0) ? LD_ENTRY : LD_MASK;
          end
        end
        LD_ENTRY: begin
          if (mem_ack) begin
            unique case (wsel)
              2'd1: begin
                stage_lo <= mem_rdata;
                wsel     <= 2'd2;
              end
              2'd2: begin
                stage_mid <= mem_rdata;
                wsel      <= 2'd3;
              end
              default: begin
                wsel    <= 2'd1;
                cnt_q   <= cnt_q - CW'(1);
                ptr_q   <= ptr_q + AW'(desc_step(wide_q));
                ent_idx <= ent_idx + IW'(1);
                if (cnt_q == CW'(1)) state <= LD_MASK;
              end
            endcase
          end
        end
        LD_MASK: begin
          if (mem_ack) begin
            state <= LD_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cam_table.sv
module cam_table #(
  parameter int N_ENT = 16,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ent_we,
  input  logic [IW-1:0]    ent_idx,
  input  logic [47:0]      ent_data,
  input  logic             mask_we,
  input  logic [N_ENT-1:0] mask_data,
  input  logic [47:0]      dst_addr,
  output logic             any_hit,
  input  logic             rd_reset_mode,
  input  logic [IW-1:0]    rd_sel,
  output logic [15:0]      rd_cap0,
  output logic [15:0]      rd_cap1,
  output logic [15:0]      rd_cap2
);

  logic [47:0]      slot [N_ENT];
  logic [N_ENT-1:0] enable_q;
  logic [N_ENT-1:0] hit_vec;

  for (genvar i = 0; i < N_ENT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot[i] <= '0;
      else if (ent_we && (ent_idx == IW'(i))) slot[i] <= ent_data;
    end
    assign hit_vec[i] = enable_q[i] && (slot[i] == dst_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable_q <= '0;
    else if (mask_we) enable_q <= mask_data;
  end

  assign any_hit = |hit_vec;

  always_comb begin
    rd_cap0 = '0;
    rd_cap1 = '0;
    rd_cap2 = '0;
    if (rd_reset_mode) begin
      rd_cap0 = slot[rd_sel][15:0];
      rd_cap1 = slot[rd_sel][31:16];
      rd_cap2 = slot[rd_sel][47:32];
    end
  end

endmodule

// File: rtl/cam_filter.sv
module cam_filter
  import cam_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_valid,
  input  logic [47:0] dst_addr,
  input  logic        promisc_en,
  input  logic        allmc_en,
  input  logic        bcast_en,
  input  logic        cam_hit,
  output logic        res_valid,
  output logic        res_accept,
  output logic [15:0] res_tag
);

  verdict_t v_next;

  assign v_next = classify(promisc_en, allmc_en, bcast_en, dst_addr, cam_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_tag    <= '0;
    end else begin
      res_valid <= frame_valid;
      if (frame_valid) begin
        res_accept <= v_next.accept;
        res_tag    <= v_next.tag;
      end
    end
  end

endmodule

// File: rtl/addr_cam_filter.sv
module addr_cam_filter #(
  parameter int AW    = 32,
  parameter int N_ENT = 16,
  localparam int CW   = 5,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_cmd,
  input  logic          wide_mode,
  input  logic [CW-1:0] cnt_init,
  input  logic [AW-1:0] ptr_init,
  output logic          load_busy,
  output logic          load_done,
  output logic [CW-1:0] cnt_q,
  output logic [AW-1:0] ptr_q,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  input  logic          promisc_en,
  input  logic          allmc_en,
  input  logic          bcast_en,
  input  logic          frame_valid,
  input  logic [47:0]   dst_addr,
  output logic          res_valid,
  output logic          res_accept,
  output logic [15:0]   res_tag,
  input  logic          rd_reset_mode,
  input  logic [IW-1:0] rd_sel,
  output logic [15:0]   rd_cap0,
  output logic [15:0]   rd_cap1,
  output logic [15:0]   rd_cap2
);

  // named internal events, observed by the bound checker
  logic          ent_commit;
  logic          mask_commit;
  logic [IW-1:0] ent_idx;
  logic [47:0]   ent_data;
  logic [15:0]   mask_word;
  logic          cam_hit;

  cam_load_seq #(.AW(AW), .N_ENT(N_ENT), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_cmd  (load_cmd),
    .wide_mode (wide_mode),
    .cnt_init  (cnt_init),
    .ptr_init  (ptr_init),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .busy      (load_busy),
    .done      (load_done),
    .cnt_q     (cnt_q),
    .ptr_q     (ptr_q),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .ent_we    (ent_commit),
    .ent_idx   (ent_idx),
    .ent_data  (ent_data),
    .mask_we   (mask_commit),
    .mask_data (mask_word)
  );

  cam_table #(.N_ENT(N_ENT)) u_table (
    .clk           (clk),
    .rst_n         (rst_n),
    .ent_we        (ent_commit),
    .ent_idx       (ent_idx),
    .ent_data      (ent_data),
    .mask_we       (mask_commit),
    .mask_data     (mask_word[N_ENT-1:0]),
    .dst_addr      (dst_addr),
    .any_hit       (cam_hit),
    .rd_reset_mode (rd_reset_mode),
    .rd_sel        (rd_sel),
    .rd_cap0       (rd_cap0),
    .rd_cap1       (rd_cap1),
    .rd_cap2       (rd_cap2)
  );

  cam_filter u_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .dst_addr    (dst_addr),
    .promisc_en  (promisc_en),
    .allmc_en    (allmc_en),
    .bcast_en    (bcast_en),
    .cam_hit     (cam_hit),
    .res_valid   (res_valid),
    .res_accept  (res_accept),
    .res_tag     (res_tag)
  );

endmodule

// File: rtl/addr_cam_filter_checker.sv
module addr_cam_filter_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_cmd,
  input logic          load_busy,
  input logic          load_done,
  input logic [4:0]    cnt_q,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          ent_commit,
  input logic          mask_commit,
  input logic          frame_valid,
  input logic          res_valid,
  input logic          res_accept,
  input logic [15:0]   res_tag,
  input logic          rd_reset_mode,
  input logic [15:0]   rd_cap0,
  input logic [15:0]   rd_cap1,
  input logic [15:0]   rd_cap2
);

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_cmd && !load_busy |=> load_busy && !load_done);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ent_commit |=> cnt_q == $past(cnt_q) - 5'd1);

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy && !ent_commit |=> $stable(cnt_q));

  assert_mask_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_commit |=> !load_busy);

  assert_done_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_busy) |-> load_done);

  assert_tag_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0(res_tag) && (res_tag == 16'h0 || res_accept));

  assert_result_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(frame_valid));

  assert_readback_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_reset_mode |-> (rd_cap0 == 16'h0) && (rd_cap1 == 16'h0) && (rd_cap2 == 16'h0));

  assert_req_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

endmodule

bind addr_cam_filter addr_cam_filter_checker #(.AW(AW)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .load_cmd      (load_cmd),
  .load_busy     (load_busy),
  .load_done     (load_done),
  .cnt_q         (cnt_q),
  .mem_req       (mem_req),
  .mem_ack       (mem_ack),
  .mem_addr      (mem_addr),
  .ent_commit    (ent_commit),
  .mask_commit   (mask_commit),
  .frame_valid   (frame_valid),
  .res_valid     (res_valid),
  .res_accept    (res_accept),
  .res_tag       (res_tag),
  .rd_reset_mode (rd_reset_mode),
  .rd_cap0       (rd_cap0),
  .rd_cap1       (rd_cap1),
  .rd_cap2       (rd_cap2)
);

// File: tb/addr_cam_filter_bench.sv
`timescale 1ns/1ps
module addr_cam_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_cmd = 1'b0;
  logic        wide_mode = 1'b0;
  logic [4:0]  cnt_init = '0;
  logic [31:0] ptr_init = '0;
  logic        load_busy, load_done;
  logic [4:0]  cnt_q;
  logic [31:0] ptr_q;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [15:0] mem_rdata;
  logic        promisc_en = 1'b0, allmc_en = 1'b0, bcast_en = 1'b0;
  logic        frame_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        res_valid, res_accept;
  logic [15:0] res_tag;
  logic        rd_reset_mode = 1'b0;
  logic [3:0]  rd_sel = '0;
  logic [15:0] rd_cap0, rd_cap1, rd_cap2;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  addr_cam_filter u_addr_cam_filter (
    .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .wide_mode(wide_mode),
    .cnt_init(cnt_init), .ptr_init(ptr_init), .load_busy(load_busy), .load_done(load_done),
    .cnt_q(cnt_q), .ptr_q(ptr_q), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .promisc_en(promisc_en),
    .allmc_en(allmc_en), .bcast_en(bcast_en), .frame_valid(frame_valid),
    .dst_addr(dst_addr), .res_valid(res_valid), .res_accept(res_accept),
    .res_tag(res_tag), .rd_reset_mode(rd_reset_mode), .rd_sel(rd_sel),
    .rd_cap0(rd_cap0), .rd_cap1(rd_cap1), .rd_cap2(rd_cap2)
  );

  // word memory with one wait cycle per read
  logic [15:0] mem [0:255];
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[8:1]];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  typedef struct packed {
    logic        pro;
    logic        amc;
    logic        brd;
    logic [47:0] dst;
    logic        acc;
    logic [15:0] tag;
  } vec_t;

  localparam logic [47:0] E0 = 48'h665544332211;
  localparam logic [47:0] E1 = 48'hFFEEDDCCBB0A;
  localparam logic [47:0] E2 = 48'h070605040302;
  localparam logic [47:0] BC = 48'hFFFFFFFFFFFF;

  localparam vec_t VECS [0:10] = '{
    '{1'b0, 1'b0, 1'b0, E0,             1'b1, 16'h0000}, // R10 enabled slot 0
    '{1'b0, 1'b0, 1'b0, E1,             1'b0, 16'h0000}, // R10 disabled slot 1
    '{1'b0, 1'b0, 1'b0, E2,             1'b1, 16'h0000}, // R10 enabled slot 2
    '{1'b0, 1'b0, 1'b0, BC,             1'b0, 16'h0000}, // R9 broadcast off
    '{1'b0, 1'b0, 1'b1, BC,             1'b1, 16'h0080}, // R9 broadcast on
    '{1'b0, 1'b1, 1'b0, 48'h000000000001, 1'b1, 16'h0100}, // R8 group bit
    '{1'b0, 1'b1, 1'b1, BC,             1'b1, 16'h0100}, // R8 over R9
    '{1'b1, 1'b0, 1'b0, 48'h123456789A00, 1'b1, 16'h0000}, // R7 unicast
    '{1'b1, 1'b0, 1'b0, 48'h000000000003, 1'b0, 16'h0000}, // R7 group falls through
    '{1'b1, 1'b0, 1'b1, BC,             1'b1, 16'h0080}, // R7 then R9
    '{1'b0, 1'b0, 1'b0, 48'h665544332212, 1'b0, 16'h0000}  // R10 one byte off
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start_load(input logic wide, input logic [4:0] cnt, input logic [31:0] ptr);
    @(negedge clk);
    wide_mode = wide;
    cnt_init  = cnt;
    ptr_init  = ptr;
    load_cmd  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_cmd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 500 && load_busy; k++) @(negedge clk);
  endtask

  task automatic lookup(input logic pro, input logic amc, input logic brd, input logic [47:0] d);
    @(negedge clk);
    promisc_en  = pro;
    allmc_en    = amc;
    bcast_en    = brd;
    dst_addr    = d;
    frame_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h1111 * 16'(i[3:0]);
    // 16-bit list at 0x100, three entries, mask word 0x0005
    mem[8'h80] = 16'hDEAD; mem[8'h81] = 16'h2211; mem[8'h82] = 16'h4433; mem[8'h83] = 16'h6655;
    mem[8'h84] = 16'hBEEF; mem[8'h85] = 16'hBB0A; mem[8'h86] = 16'hDDCC; mem[8'h87] = 16'hFFEE;
    mem[8'h88] = 16'hCAFE; mem[8'h89] = 16'h0302; mem[8'h8A] = 16'h0504; mem[8'h8B] = 16'h0706;
    mem[8'h8C] = 16'h0005;
    // 32-bit list at 0x180, one entry, mask word 0x0001
    mem[8'hC1] = 16'hAAAA; mem[8'hC2] = 16'h5040; mem[8'hC4] = 16'h7060; mem[8'hC6] = 16'h9080;
    mem[8'hC8] = 16'h0001;
    // mask-only descriptor at 0x1A0
    mem[8'hD0] = 16'h0004;

    repeat (3) @(negedge clk);
    rd_reset_mode = 1'b1;
    @(negedge clk);
    check("R5 reset busy", 64'(load_busy), 64'd0);
    check("R5 reset done", 64'(load_done), 64'd0);
    check("R10 reset valid", 64'(res_valid), 64'd0);
    check("R11 reset slot", 64'(rd_cap0), 64'd0);
    rst_n = 1'b1;
    rd_reset_mode = 1'b0;

    // R1: second command during the load must be ignored
    start_load(1'b0, 5'd3, 32'h100);
    ptr_init = 32'h40;
    cnt_init = 5'd7;
    load_cmd = 1'b1;
    @(negedge clk);
    load_cmd = 1'b0;
    check("R1 busy after start", 64'(load_busy), 64'd1);
    wait_idle();
    check("R5 busy cleared", 64'(load_busy), 64'd0);
    check("R5 done set", 64'(load_done), 64'd1);
    check("R1 R3 pointer", 64'(ptr_q), 64'h118);
    check("R3 count", 64'(cnt_q), 64'd0);

    foreach (VECS[i]) begin
      lookup(VECS[i].pro, VECS[i].amc, VECS[i].brd, VECS[i].dst);
      check("R10 valid", 64'(res_valid), 64'd1);
      check("R7-R10 accept", 64'(res_accept), 64'(VECS[i].acc));
      check("R8 R9 tag", 64'(res_tag), 64'(VECS[i].tag));
    end
    promisc_en = 1'b0; allmc_en = 1'b0; bcast_en = 1'b0;

    // R2 R11 read-back
    rd_reset_mode = 1'b1;
    rd_sel = 4'd0;
    @(negedge clk);
    check("R2 R11 cap0", 64'(rd_cap0), 64'h2211);
    check("R2 R11 cap1", 64'(rd_cap1), 64'h4433);
    check("R2 R11 cap2", 64'(rd_cap2), 64'h6655);
    rd_sel = 4'd2;
    @(negedge clk);
    check("R2 R11 slot2 cap0", 64'(rd_cap0), 64'h0302);
    check("R2 R11 slot2 cap2", 64'(rd_cap2), 64'h0706);
    rd_sel = 4'd1;
    @(negedge clk);
    check("R2 R11 slot1 cap1", 64'(rd_cap1), 64'hDDCC);
    rd_reset_mode = 1'b0;
    @(negedge clk);
    check("R11 gated off", 64'({rd_cap0, rd_cap1, rd_cap2}), 64'd0);

    // R6 wide layout
    start_load(1'b1, 5'd1, 32'h180);
    wait_idle();
    check("R6 pointer", 64'(ptr_q), 64'h190);
    check("R6 done", 64'(load_done), 64'd1);
    lookup(1'b0, 1'b0, 1'b0, 48'h908070605040);
    check("R6 new slot 0 accepted", 64'(res_accept), 64'd1);
    lookup(1'b0, 1'b0, 1'b0, E0);
    check("R6 old slot 0 gone", 64'(res_accept), 64'd0);
    lookup(1'b0, 1'b0, 1'b0, E2);
    check("R4 slot 2 masked", 64'(res_accept), 64'd0);

    // R12 R4: zero-count load, lookup on the mask-commit edge
    @(negedge clk);
    wide_mode = 1'b0;
    cnt_init  = 5'd0;
    ptr_init  = 32'h1A0;
    load_cmd  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_cmd = 1'b0;
    @(posedge clk);
    @(negedge clk);
    dst_addr    = E2;
    frame_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_valid = 1'b0;
    check("R12 same-edge valid", 64'(res_valid), 64'd1);
    check("R12 same-edge uses old mask", 64'(res_accept), 64'd0);
    check("R5 done with mask", 64'(load_done), 64'd1);
    check("R4 busy cleared", 64'(load_busy), 64'd0);
    lookup(1'b0, 1'b0, 1'b0, E2);
    check("R12 next edge new mask", 64'(res_accept), 64'd1);
    check("R4 zero-count pointer", 64'(ptr_q), 64'h1A0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule